// File: doc/BRIEF.md
# Weight-Stationary Systolic Matrix Multiplier

This block multiplies a stream of signed activation vectors by a square signed weight matrix held inside a grid of multiply-accumulate cells. The caller first writes the weight matrix into the grid, one row per clock. After that it presents one activation vector per clock for as long as it likes. Inside the grid, each weight stays in its own cell. Each activation element travels rightward along its row, and partial sums travel downward along each column. Each cell adds its own product to the partial sum it receives from the cell above.

The block owns all of the timing alignment. Row `i` of each input vector is held back by `i` cycles before it enters the grid, so that each operand meets the correct partial sum. Column `j` of the result is held back by `DIM-1-j` cycles after it leaves the bottom row, so that a complete result vector appears in a single cycle. A valid flag travels alongside the data through a fixed-length pipeline, so there is no flow control and no bubble between vectors. The block treats every operand the same way, zeros included, and has no data-dependent path.

Top module: `ws_systolic_mm`

## Requirements
- R1: During reset and after it, `res_valid` is 0, `res_vec` is all zeros and every stored weight is 0. A vector sent before any weight load therefore produces an all-zero result.
- R2: For a valid input vector `x`, result lane `j` equals the signed sum over `i` of `x[i]*W[i][j]`, kept at full precision in `ACC_W` bits. Activation lane `i` is `act_vec[i*A_W +: A_W]`, result lane `j` is `res_vec[j*ACC_W +: ACC_W]`, and all values are two's complement.
- R3: An activation moves one cell to the right per clock, and a partial sum moves one cell down per clock. The top row of the grid starts every column sum at zero.
- R4: All lanes of a result appear together on `res_valid`. This happens exactly `2*DIM-1` rising edges after the edge that samples the input vector (7 edges at the default size).
- R5: While `wload_en` is high, each edge writes `wload_row` into the next grid row. Lane `j` (`wload_row[j*W_W +: W_W]`) goes to column `j`. A burst always starts at row 0 and wraps from row `DIM-1` back to row 0. Any cycle with `wload_en` low sends the next burst back to row 0.
- R6: Stored weights do not change on cycles when `wload_en` is low, whatever is on `wload_row`. One load serves any number of later vectors.
- R7: One vector is accepted on every cycle that `act_valid` is high, with no gaps required. Every accepted vector produces exactly one valid result, and cycles with `act_valid` low produce none.
- R8: Zero operands take the same path and the same latency as any other operand. A zero activation vector, or zero weights, produce a zero contribution.
- R9: The caller must not assert `wload_en` while `act_valid` is high or while any accepted vector is still in the pipeline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wload_en | input | 1 | Weight-row write strobe |
| wload_row | input | DIM*W_W | One weight row, lane j for column j |
| act_valid | input | 1 | Activation vector is present |
| act_vec | input | DIM*A_W | Activation vector, lane i for grid row i |
| res_valid | output | 1 | Result vector is present |
| res_vec | output | DIM*ACC_W | Result vector, lane j for column j |

## Verification
Every result is due exactly `2*DIM-1` rising edges after the edge that samples its input vector. When the bench drives a vector, it records the expected result together with the cycle number at which that result must appear. A monitor running on the falling edge compares each due entry with `res_valid` and `res_vec` in that cycle only. It also flags a valid result in any cycle where none is due. Before each weight load, the bench idles for more than the pipeline latency, so no load overlaps a vector that is still in flight.

// File: rtl/ws_mm_pkg.sv
`timescale 1ns/1ps
package ws_mm_pkg;
   // Rising edges from input sample to aligned result: skew + grid + deskew.
   function automatic int pipe_latency(input int dim);
      return 2 * dim - 1;
   endfunction

   // Width of a plain index into dim items (at least one bit).
   function automatic int idx_width(input int dim);
      return (dim > 1) ? $clog2(dim) : 1;
   endfunction

   // Bits needed for a full-precision dot product of dim terms.
   function automatic int dot_width(input int aw, input int ww, input int dim);
      return aw + ww + ((dim > 1) ? $clog2(dim) : 0);
   endfunction
endpackage

// File: rtl/ws_delay_line.sv
`timescale 1ns/1ps
module ws_delay_line #(
   parameter int W     = 8,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   if (W < 1) begin : g_bad_w
      $error("ws_delay_line: W must be at least 1");
   end
   if (DEPTH < 0) begin : g_bad_depth
      $error("ws_delay_line: DEPTH must not be negative");
   end

   if (DEPTH == 0) begin : g_wire
      assign dout = din;
   end else begin : g_regs
      logic [W-1:0] stg [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) stg[k] <= '0;
         end else begin
            stg[0] <= din;
            for (int k = 1; k < DEPTH; k++) stg[k] <= stg[k-1];
         end
      end

      assign dout = stg[DEPTH-1];
   end
endmodule

// File: rtl/ws_mac_cell.sv
`timescale 1ns/1ps
module ws_mac_cell #(
   parameter int A_W   = 8,
   parameter int W_W   = 8,
   parameter int ACC_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ld_en,
   input  logic signed [W_W-1:0]   w_in,
   input  logic signed [A_W-1:0]   a_in,
   input  logic signed [ACC_W-1:0] p_in,
   output logic signed [A_W-1:0]   a_out,
   output logic signed [ACC_W-1:0] p_out
);
   localparam int PW = A_W + W_W;

   if (ACC_W < PW) begin : g_bad_acc
      $error("ws_mac_cell: ACC_W narrower than one product");
   end

   logic signed [W_W-1:0]   w_q;
   logic signed [PW-1:0]    prod;
   logic signed [ACC_W-1:0] p_next;

   // Same arithmetic every cycle: no operand-dependent path.
   always_comb begin
      prod   = a_in * w_q;
      p_next = p_in + {{(ACC_W-PW){prod[PW-1]}}, prod};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         w_q   <= '0;
         a_out <= '0;
         p_out <= '0;
      end else begin
         if (ld_en) w_q <= w_in;
         a_out <= a_in;
         p_out <= p_next;
      end
   end
endmodule

// File: rtl/ws_systolic_mm.sv
`timescale 1ns/1ps
module ws_systolic_mm #(
   parameter int DIM   = 4,
   parameter int A_W   = 8,
   parameter int W_W   = 8,
   parameter int ACC_W = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wload_en,
   input  logic [DIM*W_W-1:0]   wload_row,
   input  logic                 act_valid,
   input  logic [DIM*A_W-1:0]   act_vec,
   output logic                 res_valid,
   output logic [DIM*ACC_W-1:0] res_vec
);
   localparam int LAT   = ws_mm_pkg::pipe_latency(DIM);
   localparam int PTR_W = ws_mm_pkg::idx_width(DIM);
   localparam int CNT_W = $clog2(LAT + 2);
   localparam int NEED  = ws_mm_pkg::dot_width(A_W, W_W, DIM);

   if (DIM < 1) begin : g_bad_dim
      $error("ws_systolic_mm: DIM must be at least 1");
   end
   if (A_W < 2 || W_W < 2) begin : g_bad_op
      $error("ws_systolic_mm: operand widths must be at least 2");
   end
   if (ACC_W < NEED) begin : g_bad_acc
      $error("ws_systolic_mm: ACC_W too narrow for a full dot product");
   end

   // ---------------- weight row pointer ----------------
   logic [PTR_W-1:0] row_ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                          row_ptr <= '0;
      else if (!wload_en)                  row_ptr <= '0;
      else if (row_ptr == PTR_W'(DIM - 1)) row_ptr <= '0;
      else                                 row_ptr <= row_ptr + 1'b1;
   end

   AST_ROW_PTR: assert property (@(posedge clk) disable iff (!rst_n)
      row_ptr <= PTR_W'(DIM - 1)) else $error("row pointer out of range"); // R5

   // ---------------- grid ----------------
   logic signed [A_W-1:0]   row_in [DIM];
   logic signed [A_W-1:0]   a_g    [DIM][DIM];
   logic signed [ACC_W-1:0] p_g    [DIM][DIM];

   for (genvar i = 0; i < DIM; i++) begin : g_row
      // Row i enters i cycles late.
      ws_delay_line #(.W(A_W), .DEPTH(i)) i_skew (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (act_vec[i*A_W +: A_W]),
         .dout (row_in[i])
      );

      for (genvar j = 0; j < DIM; j++) begin : g_col
         logic signed [A_W-1:0]   a_src;
         logic signed [ACC_W-1:0] p_src;
         logic                    ld_here;

         if (j == 0) begin : g_left
            assign a_src = row_in[i];
         end else begin : g_inner
            assign a_src = a_g[i][j-1];
            AST_ACT_HOP: assert property (@(posedge clk) disable iff (!rst_n)
               a_g[i][j] == $past(a_g[i][j-1])) else $error("activation hop"); // R3
         end

         if (i == 0) begin : g_top
            assign p_src = '0;
         end else begin : g_below
            assign p_src = p_g[i-1][j];
         end

         assign ld_here = wload_en && (row_ptr == PTR_W'(i));

         ws_mac_cell #(.A_W(A_W), .W_W(W_W), .ACC_W(ACC_W)) i_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .ld_en(ld_here),
            .w_in (wload_row[j*W_W +: W_W]),
            .a_in (a_src),
            .p_in (p_src),
            .a_out(a_g[i][j]),
            .p_out(p_g[i][j])
         );
      end
   end

   // ---------------- output alignment ----------------
   for (genvar j = 0; j < DIM; j++) begin : g_deskew
      ws_delay_line #(.W(ACC_W), .DEPTH(DIM - 1 - j)) i_align (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (p_g[DIM-1][j]),
         .dout (res_vec[j*ACC_W +: ACC_W])
      );
   end

   ws_delay_line #(.W(1), .DEPTH(LAT)) i_vld (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (act_valid),
      .dout (res_valid)
   );

   // ---------------- in-flight accounting for checks ----------------
   logic [CNT_W-1:0] inflight;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) inflight <= '0;
      else        inflight <= inflight + CNT_W'(act_valid) - CNT_W'(res_valid);
   end

   AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (inflight != '0)) else $error("result without input"); // R7
   AST_INFLIGHT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      inflight <= CNT_W'(LAT)) else $error("too many vectors in flight"); // R7
   AST_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      wload_en |-> (!act_valid && inflight == '0)) else $error("load during stream"); // R9
endmodule

// File: tb/test_ws_systolic_mm.sv
`timescale 1ns/1ps
module test_ws_systolic_mm;
   localparam int DIM  = 4;
   localparam int AW   = 8;
   localparam int WW   = 8;
   localparam int ACCW = 32;
   localparam int LAT  = 2 * DIM - 1;
   localparam int NACT = 10;

   // Stimulus table: byte lane i feeds grid row i.
   localparam logic [DIM*AW-1:0] ACT_TBL [NACT] = '{
      32'h04030201, 32'h00000000, 32'h80808080, 32'h7F7F7F7F, 32'hFF01FF01,
      32'h7F807F80, 32'h00000001, 32'h10000000, 32'hC3A55A3C, 32'h01020304
   };
   localparam logic [DIM*WW-1:0] W_TBL [DIM] = '{
      32'h04030201, 32'hFDFEFF00, 32'h7F80017F, 32'h10F0C040
   };

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  wload_en = 1'b0;
   logic [DIM*WW-1:0]     wload_row = '0;
   logic                  act_valid = 1'b0;
   logic [DIM*AW-1:0]     act_vec = '0;
   logic                  res_valid;
   logic [DIM*ACCW-1:0]   res_vec;

   always #4 clk = ~clk;

   ws_systolic_mm #(.DIM(DIM), .A_W(AW), .W_W(WW), .ACC_W(ACCW)) i_ws_systolic_mm (
      .clk(clk), .rst_n(rst_n), .wload_en(wload_en), .wload_row(wload_row),
      .act_valid(act_valid), .act_vec(act_vec), .res_valid(res_valid), .res_vec(res_vec)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 1'b0;
   string tag = "R2";

   int bw [DIM][DIM];
   int bptr = 0;

   logic [DIM*ACCW-1:0] exp_q [$];
   int                  due_q [$];
   string               tag_q [$];

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [DIM*ACCW-1:0] ref_mul(input logic [DIM*AW-1:0] a);
      logic [DIM*ACCW-1:0] r;
      for (int j = 0; j < DIM; j++) begin
         longint s = 0;
         for (int i = 0; i < DIM; i++)
            s += longint'($signed(a[i*AW +: AW])) * longint'(bw[i][j]);
         r[j*ACCW +: ACCW] = s[ACCW-1:0];
      end
      return r;
   endfunction

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         wload_en  = 1'b0;
         wload_row = $urandom;
         act_valid = 1'b0;
         act_vec   = $urandom;
         bptr      = 0;
      end
   endtask

   task automatic send(input logic [DIM*AW-1:0] a);
      @(negedge clk);
      wload_en  = 1'b0;
      wload_row = $urandom;
      act_valid = 1'b1;
      act_vec   = a;
      bptr      = 0;
      exp_q.push_back(ref_mul(a));
      due_q.push_back(cyc + LAT);
      tag_q.push_back(tag);
   endtask

   // R9: callers only load after the pipeline has drained.
   task automatic load_row(input logic [DIM*WW-1:0] row);
      @(negedge clk);
      wload_en  = 1'b1;
      wload_row = row;
      act_valid = 1'b0;
      for (int j = 0; j < DIM; j++) bw[bptr][j] = int'($signed(row[j*WW +: WW]));
      bptr = (bptr + 1) % DIM;
   endtask

   task automatic drain();
      idle(LAT + 2);
   endtask

   // Scoreboard: each result is due exactly LAT edges after its input edge.
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (due_q.size() > 0 && due_q[0] == cyc) begin
            checks++;
            if (res_valid !== 1'b1 || res_vec !== exp_q[0]) begin
               fails++;
               $display("FAIL %s: cycle %0d valid=%b vec=%h expected valid=1 vec=%h",
                        tag_q[0], cyc, res_valid, res_vec, exp_q[0]);
            end
            void'(exp_q.pop_front());
            void'(due_q.pop_front());
            void'(tag_q.pop_front());
         end else if (res_valid !== 1'b0) begin
            checks++;
            fails++;
            $display("FAIL R7: cycle %0d valid=%b expected valid=0", cyc, res_valid);
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         fails++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DIM; i++)
         for (int j = 0; j < DIM; j++) bw[i][j] = 0;

      // R1: reset state
      repeat (3) @(negedge clk);
      checks++;
      if (res_valid !== 1'b0 || res_vec !== '0) begin
         fails++;
         $display("FAIL R1: in reset valid=%b vec=%h expected 0/0", res_valid, res_vec);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (res_valid !== 1'b0 || res_vec !== '0) begin
         fails++;
         $display("FAIL R1: after reset valid=%b vec=%h expected 0/0", res_valid, res_vec);
      end
      // R1: weights reset to zero, so any vector gives zero.
      tag = "R1";
      send(32'h7F80FF01);
      drain();

      // R5: load the matrix, then walk the table back to back (R2 R3 R4 R7 R8).
      for (int i = 0; i < DIM; i++) load_row(W_TBL[i]);
      idle(1);
      tag = "R2/R3/R4/R7/R8";
      for (int k = 0; k < NACT; k++) send(ACT_TBL[k]);
      idle(3);

      // R7: gaps with garbage data between valid vectors.
      tag = "R7";
      for (int k = 0; k < NACT; k++) begin
         send(ACT_TBL[NACT-1-k]);
         idle(k % 3);
      end

      // R6: weights survive idle cycles with a toggling load bus.
      idle(20);
      tag = "R6";
      send(32'h05FB11EE);
      send(32'h80808080);
      drain();

      // R2: extreme operands, all -128 weights and activations.
      for (int i = 0; i < DIM; i++) load_row(32'h80808080);
      idle(1);
      tag = "R2";
      send(32'h80808080);
      send(32'h7F7F7F7F);
      drain();

      // R8: all-zero weights give zero results at normal latency.
      for (int i = 0; i < DIM; i++) load_row(32'h00000000);
      idle(1);
      tag = "R8";
      send(32'h7F80C3A5);
      send(32'h00000000);
      drain();

      // R5: a gap in the strobe restarts the row pointer at row 0.
      for (int i = 0; i < DIM; i++) load_row(W_TBL[i]);
      idle(1);
      load_row(32'h11223344);
      load_row(32'hF0E0D0C0);
      idle(1);
      tag = "R5";
      send(32'h01010101);
      send(32'h0A00FF7F);
      drain();

      // R5: a burst of DIM+1 rows wraps onto row 0.
      for (int i = 0; i <= DIM; i++) load_row(32'h01020304 + 32'(i * 32'h11111111));
      idle(1);
      tag = "R5";
      send(32'h01000000);
      send(32'h00000001);
      send(32'h807F0180);
      drain();

      // R2: random operands with random gaps.
      for (int r = 0; r < 3; r++) begin
         for (int i = 0; i < DIM; i++) load_row($urandom);
         idle(1);
         tag = "R2/R7";
         for (int k = 0; k < 20; k++) begin
            send($urandom);
            if ($urandom % 4 == 0) idle(1);
         end
         drain();
      end

      idle(4);
      checks++;
      if (exp_q.size() != 0) begin
         fails++;
         $display("FAIL R7: %0d results never appeared, expected 0", exp_q.size());
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule